// File: doc/BRIEF.md
# Split-Screen Display Address Generator

This block produces the frame-buffer base address of each scan line for a text or graphics display controller, together with the running scan-line number and the horizontal pel-pan value the display pipeline should apply to that line. A timing generator supplies one strobe at the end of every scan line and another at the end of every frame. On each line strobe the base address steps forward by a programmed line offset.

The upper part of the screen starts at a programmable start address, so rewriting that address scrolls the image. A 10-bit line-compare value splits the screen. On the line strobe where the scan-line count equals the compare value, the address counter is forced to zero. The lines below the split then show frame-buffer memory from address 0 onward, unaffected by both the start address and the pan value.

A byte-wide register port, addressed by an 8-bit index, holds the programming. Its values are copied into the working state only at a frame boundary, so a write made partway through a frame never tears the picture.

Top module: `split_addr_gen`

## Requirements
- R1: After reset, line_addr, scan_line and pan_out are 0, and every register index reads back 00h.
- R2: A byte written to index 07h, 09h, 0Ch, 0Dh, 08h, 13h or 18h reads back unchanged, all eight bits, on rd_data when rd_index selects that index.
- R3: The compare value is 10 bits wide. Bits 7:0 are index 18h, bit 8 is index 07h bit 4, and bit 9 is index 09h bit 6. All three parts take part in the comparison, and no other bit of 07h or 09h does.
- R4: On an end-of-frame strobe, scan_line becomes 0 and line_addr becomes the start address {index 0Ch, index 0Dh}, with 0Ch as the high byte. pan_out becomes index 08h bits 3:0.
- R5: On an end-of-line strobe with no match, line_addr increases by the 8-bit line offset in index 13h, and scan_line increases by 1.
- R6: On an end-of-line strobe where scan_line equals the compare value, line_addr becomes 0. Later lines then advance from 0 by the line offset.
- R7: From the line after the match until the next end-of-frame strobe, pan_out is 0.
- R8: A register write made during a frame leaves line_addr, scan_line and pan_out unaffected. It takes effect at the next end-of-frame strobe.
- R9: When the compare value is never reached before the frame ends, no split occurs, and every line advances by the line offset from the start address.
- R10: When end-of-line and end-of-frame strobes arrive in the same cycle, the end-of-frame action alone is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_index | input | 8 | Register index for a write |
| wr_data | input | 8 | Register write byte |
| rd_index | input | 8 | Register index for readback |
| rd_data | output | 8 | Byte held at rd_index (00h for an unused index) |
| eol | input | 1 | End-of-line strobe |
| eof | input | 1 | End-of-frame strobe |
| line_addr | output | ADDR_W | Frame-buffer base address of the current line |
| scan_line | output | 10 | Current scan-line number |
| pan_out | output | PAN_W | Effective pel-pan value for the current line |

## Verification
The bench places the split at line 3. A design that compared one line late, or cleared the address on the matching line itself, would show a nonzero address or a leftover pan value on the fourth line. Compare values of 105h and 200h each check a high compare bit: a design that dropped or misrouted bit 8 or bit 9 would split at line 5, or at line 0, or not at all. Writes made partway through a frame expose a design that applies its registers at once, because the address step or pan value would change on the next line. Simultaneous strobes and a compare value beyond the end of the frame cover a wrong strobe priority and a spurious split.

// File: rtl/split_addr_gen.sv
module split_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int PAN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_index,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        rd_index,
  output logic [7:0]        rd_data,
  input  logic              eol,
  input  logic              eof,
  output logic [ADDR_W-1:0] line_addr,
  output logic [9:0]        scan_line,
  output logic [PAN_W-1:0]  pan_out
);
  localparam int LINE_W = 10;
  localparam logic [7:0] IX_OVF  = 8'h07;
  localparam logic [7:0] IX_PAN  = 8'h08;
  localparam logic [7:0] IX_MSL  = 8'h09;
  localparam logic [7:0] IX_STH  = 8'h0C;
  localparam logic [7:0] IX_STL  = 8'h0D;
  localparam logic [7:0] IX_OFF  = 8'h13;
  localparam logic [7:0] IX_CMP  = 8'h18;

  logic [7:0] r_ovf, r_msl, r_cmp, r_sth, r_stl, r_off, r_pan;

  logic [LINE_W-1:0] cmp_act;
  logic [7:0]        off_act;
  logic [PAN_W-1:0]  pan_act;
  logic              pan_dis;

  logic [LINE_W-1:0] cmp_prog;
  logic [15:0]       start16;
  logic [ADDR_W-1:0] start_prog;
  logic              split_hit;

  assign cmp_prog   = {r_msl[6], r_ovf[4], r_cmp};
  assign start16    = {r_sth, r_stl};
  assign start_prog = ADDR_W'(start16);
  assign split_hit  = (scan_line == cmp_act);
  assign pan_out    = pan_dis ? '0 : pan_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_ovf <= '0;
      r_msl <= '0;
      r_cmp <= '0;
      r_sth <= '0;
      r_stl <= '0;
      r_off <= '0;
      r_pan <= '0;
    end else if (wr_en) begin
      case (wr_index)
        IX_OVF:  r_ovf <= wr_data;
        IX_MSL:  r_msl <= wr_data;
        IX_CMP:  r_cmp <= wr_data;
        IX_STH:  r_sth <= wr_data;
        IX_STL:  r_stl <= wr_data;
        IX_OFF:  r_off <= wr_data;
        IX_PAN:  r_pan <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (rd_index)
      IX_OVF:  rd_data = r_ovf;
      IX_MSL:  rd_data = r_msl;
      IX_CMP:  rd_data = r_cmp;
      IX_STH:  rd_data = r_sth;
      IX_STL:  rd_data = r_stl;
      IX_OFF:  rd_data = r_off;
      IX_PAN:  rd_data = r_pan;
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_act   <= '0;
      off_act   <= '0;
      pan_act   <= '0;
      pan_dis   <= 1'b0;
      line_addr <= '0;
      scan_line <= '0;
    end else if (eof) begin
      cmp_act   <= cmp_prog;
      off_act   <= r_off;
      pan_act   <= r_pan[PAN_W-1:0];
      pan_dis   <= 1'b0;
      line_addr <= start_prog;
      scan_line <= '0;
    end else if (eol) begin
      scan_line <= scan_line + 1'b1;
      if (split_hit) begin
        line_addr <= '0;
        pan_dis   <= 1'b1;
      end else begin
        line_addr <= line_addr + ADDR_W'(off_act);
      end
    end
  end
endmodule

module split_addr_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int PAN_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eol,
  input logic              eof,
  input logic [ADDR_W-1:0] line_addr,
  input logic [9:0]        scan_line,
  input logic [PAN_W-1:0]  pan_out,
  input logic [9:0]        cmp_act,
  input logic              pan_dis
);
  AST_FRAME_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> scan_line == 10'd0); // R4
  AST_LINE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eol && !eof) |=> scan_line == $past(scan_line) + 10'd1); // R5
  AST_SPLIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (eol && !eof && scan_line == cmp_act) |=> (line_addr == '0 && pan_out == '0)); // R6
  AST_PAN_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pan_dis && !eof) |=> (pan_dis && pan_out == '0)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!eol && !eof) |=> ($stable(line_addr) && $stable(scan_line) && $stable(pan_out))); // R8
  AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (eol && eof) |=> scan_line == 10'd0); // R10
endmodule

bind split_addr_gen split_addr_gen_chk #(.ADDR_W(ADDR_W), .PAN_W(PAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eol(eol), .eof(eof), .line_addr(line_addr),
  .scan_line(scan_line), .pan_out(pan_out), .cmp_act(cmp_act), .pan_dis(pan_dis)
);

// File: tb/split_addr_gen_bench.sv
module split_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_index = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_index = '0;
  logic [7:0]  rd_data;
  logic        eol = 1'b0;
  logic        eof = 1'b0;
  logic [15:0] line_addr;
  logic [9:0]  scan_line;
  logic [3:0]  pan_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  split_addr_gen u_split_addr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_index(wr_index), .wr_data(wr_data),
    .rd_index(rd_index), .rd_data(rd_data), .eol(eol), .eof(eof),
    .line_addr(line_addr), .scan_line(scan_line), .pan_out(pan_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] idx, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_index = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] idx, logic [7:0] exp);
    rd_index = idx;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic strobe(bit l, bit f);
    @(negedge clk);
    eol = l; eof = f;
    @(negedge clk);
    eol = 1'b0; eof = 1'b0;
  endtask

  task automatic chk_out(string tag, int a, int ln, int p);
    chk({tag, " addr"}, line_addr, a);
    chk({tag, " line"}, scan_line, ln);
    chk({tag, " pan"}, pan_out, p);
  endtask

  task automatic t_reset;
    chk_out("R1 reset", 0, 0, 0);
    rd_chk("R1 reg18", 8'h18, 8'h00);
    rd_chk("R1 reg07", 8'h07, 8'h00);
    rd_chk("R1 reg09", 8'h09, 8'h00);
  endtask

  task automatic t_regs;
    wr(8'h18, 8'hA5); wr(8'h07, 8'h5A); wr(8'h09, 8'hC3);
    wr(8'h0C, 8'h12); wr(8'h0D, 8'h34); wr(8'h13, 8'h28); wr(8'h08, 8'h07);
    rd_chk("R2 18h", 8'h18, 8'hA5);
    rd_chk("R2 07h", 8'h07, 8'h5A);
    rd_chk("R2 09h", 8'h09, 8'hC3);
    rd_chk("R2 0Ch", 8'h0C, 8'h12);
    rd_chk("R2 0Dh", 8'h0D, 8'h34);
    rd_chk("R2 13h", 8'h13, 8'h28);
    rd_chk("R2 08h", 8'h08, 8'h07);
    chk_out("R8 regs no effect", 0, 0, 0);
  endtask

  task automatic t_split;
    wr(8'h0C, 8'h01); wr(8'h0D, 8'h00); wr(8'h13, 8'h28);
    wr(8'h18, 8'h03); wr(8'h07, 8'hEF); wr(8'h09, 8'hBF); wr(8'h08, 8'h05);
    strobe(0, 1);
    chk_out("R4 frame start", 16'h0100, 0, 5);
    strobe(1, 0); chk_out("R5 line1", 16'h0128, 1, 5);
    strobe(1, 0); chk_out("R5 line2", 16'h0150, 2, 5);
    strobe(1, 0); chk_out("R5 line3", 16'h0178, 3, 5);
    strobe(1, 0); chk_out("R6 R7 split line", 16'h0000, 4, 0);
    strobe(1, 0); chk_out("R6 R7 below split", 16'h0028, 5, 0);
    strobe(1, 0); chk_out("R7 still off", 16'h0050, 6, 0);
    strobe(0, 1); chk_out("R4 pan restored", 16'h0100, 0, 5);
  endtask

  task automatic t_defer;
    strobe(1, 0); chk_out("R8 pre", 16'h0128, 1, 5);
    wr(8'h0D, 8'h80); wr(8'h13, 8'h10); wr(8'h08, 8'h09); wr(8'h18, 8'h01);
    chk_out("R8 after write", 16'h0128, 1, 5);
    strobe(1, 0); chk_out("R8 old offset kept", 16'h0150, 2, 5);
    strobe(0, 1); chk_out("R8 new frame", 16'h0180, 0, 9);
    strobe(1, 0); chk_out("R8 new offset", 16'h0190, 1, 9);
    strobe(1, 0); chk_out("R8 new compare", 16'h0000, 2, 0);
  endtask

  task automatic t_cmp10;
    wr(8'h0C, 8'h00); wr(8'h0D, 8'h00); wr(8'h13, 8'h01);
    wr(8'h18, 8'h05); wr(8'h07, 8'h10); wr(8'h09, 8'h00);
    strobe(0, 1);
    for (int i = 0; i < 6; i++) strobe(1, 0);
    chk_out("R3 bit8 no early split", 6, 6, 9);
    for (int i = 6; i < 16'h105; i++) strobe(1, 0);
    chk_out("R3 bit8 at line", 16'h0105, 16'h105, 9);
    strobe(1, 0);
    chk_out("R3 bit8 split", 0, 16'h106, 0);
    wr(8'h18, 8'h00); wr(8'h07, 8'hEF); wr(8'h09, 8'h40);
    strobe(0, 1);
    strobe(1, 0);
    chk_out("R3 bit9 no split at 0", 1, 1, 9);
    for (int i = 1; i < 16'h200; i++) strobe(1, 0);
    chk_out("R3 bit9 at line", 16'h0200, 16'h200, 9);
    strobe(1, 0);
    chk_out("R3 bit9 split", 0, 16'h201, 0);
  endtask

  task automatic t_nosplit;
    wr(8'h0C, 8'h00); wr(8'h0D, 8'h40); wr(8'h13, 8'h08);
    wr(8'h18, 8'hFF); wr(8'h07, 8'h10); wr(8'h09, 8'h40);
    strobe(0, 1);
    for (int i = 0; i < 20; i++) strobe(1, 0);
    chk_out("R9 no split", 16'h00E0, 20, 9);
    strobe(0, 1);
    chk_out("R9 next frame", 16'h0040, 0, 9);
  endtask

  task automatic t_collide;
    strobe(1, 0); strobe(1, 0);
    chk_out("R10 pre", 16'h0050, 2, 9);
    strobe(1, 1);
    chk_out("R10 both strobes", 16'h0040, 0, 9);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_split();
    t_defer();
    t_cmp10();
    t_nosplit();
    t_collide();
    summary();
  end
endmodule